// File: doc/BRIEF.md
# Dual-width integer ALU with iterative divider

This block is the arithmetic stage of a small virtual-machine core. A decoded operation code arrives with a class bit, the current value of the destination register, a source register value and a 32-bit immediate. The block works out the 64-bit value to write back. When `wide` is 0, the class is narrow: both operands are cut to 32 bits and the result is zero-extended. When `wide` is 1, the full 64-bit datapath is used. The second operand is the source register when `use_reg` is 1. When `use_reg` is 0, it is the immediate, sign-extended to 64 bits.

Most operations finish one cycle after `start`. Unsigned and signed divide and modulo run through a one-bit-per-cycle restoring divider. The divider takes 32 steps in the narrow class and 64 in the wide class, and `busy` is high while it runs. Every operation ends with a one-cycle `done` pulse. On that pulse, `wr_en` says that the destination should be written with `result`, and `illegal` says that the operation was rejected. The signed divide and modulo codes are accepted only when `ext_en` is set. The byte-order operation takes its width from the immediate and the target order from `use_reg`.

Top module: `pfx_alu_core`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, MUL=2 (low 64 bits of product), DIV=3, OR=4, AND=5, LSH=6, RSH=7, NEG=8 (negate destination), MOD=9, XOR=10, MOV=11 (copy second operand), ARSH=12, END=13, SDIV=14, SMOD=15. Every code other than 3, 9, 14 and 15 raises `done` on the clock edge after the one that samples `start`.
- R2: With `wide`=0, both operands are truncated to 32 bits before the operation and `result[63:32]` is 0 on completion. END is not affected by this rule.
- R3: The shift amount is the second operand masked to 5 bits (narrow) or 6 bits (wide). LSH and RSH fill with zeros. ARSH copies the class sign bit (bit 31 or bit 63).
- R4: With `use_reg`=0, the second operand is `imm_val` sign-extended to 64 bits before any class truncation. With `use_reg`=1, it is `src_val`.
- R5: DIV and MOD are unsigned. With a non-zero divisor, `busy` is high for 32 (narrow) or 64 (wide) cycles, and `done` rises on the edge that clears `busy`.
- R6: A zero divisor completes on the next edge without `busy`. DIV and SDIV give 0. MOD and SMOD give the class-truncated dividend.
- R7: With `ext_en`=1, SDIV truncates toward zero and SMOD takes the sign of the dividend, in the class width. The most negative value divided by -1 gives that same value, with remainder 0.
- R8: SDIV or SMOD with `ext_en`=0 completes on the next edge with `illegal`=1, `wr_en`=0 and `result` equal to the unchanged `dst_val`.
- R9: END takes its width (16, 32 or 64) from `imm_val` and acts on `dst_val` whatever the class. `use_reg`=0 targets little-endian and `use_reg`=1 targets big-endian. When the target matches the host order (parameter `HOST_BIG`, default 0 = little), the result is a zero-extended truncation to the width. Otherwise it is a byte reversal within the width, zero-extended.
- R10: END with any other width completes on the next edge with `illegal`=1, `wr_en`=0 and `result` equal to `dst_val`.
- R11: `start` is ignored while `busy` is high. The running division finishes with its own result and timing.
- R12: While reset is held, `busy`, `done`, `illegal` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the operation on the inputs |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| use_reg | input | 1 | Second-operand select; target byte order for END |
| ext_en | input | 1 | Allows signed divide and modulo |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Signed immediate (width for END) |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was a rejected operation |
| wr_en | output | 1 | Completion carries a value to write back |
| result | output | 64 | Value to write back |

## Verification
The hardest situation to reach is a request that arrives in the middle of a division. The divider's counter and the captured sign information must survive a second `start` that carries different operands. The bench raises `start` with an unrelated ADD a few cycles into a long wide division. It then checks on every clock that `busy`, the `done` timing and the quotient all follow the original operation. Signed corner quotients also need deliberate stimulus, because random operands almost never produce them. These are the most negative value over -1 in both classes and negative dividends with positive divisors. Zero divisors are made frequent in the random phase.

// File: rtl/pfx_alu_pkg.sv
package pfx_alu_pkg;

  localparam int unsigned XLEN = 64;
  localparam int unsigned HLEN = XLEN / 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_MUL  = 4'd2,  OP_DIV  = 4'd3,
    OP_OR   = 4'd4,  OP_AND  = 4'd5,  OP_LSH  = 4'd6,  OP_RSH  = 4'd7,
    OP_NEG  = 4'd8,  OP_MOD  = 4'd9,  OP_XOR  = 4'd10, OP_MOV  = 4'd11,
    OP_ARSH = 4'd12, OP_END  = 4'd13, OP_SDIV = 4'd14, OP_SMOD = 4'd15
  } alu_op_e;

  function automatic logic is_div_op(alu_op_e o);
    return (o == OP_DIV) || (o == OP_MOD) || (o == OP_SDIV) || (o == OP_SMOD);
  endfunction

  function automatic logic is_signed_div(alu_op_e o);
    return (o == OP_SDIV) || (o == OP_SMOD);
  endfunction

endpackage

// File: rtl/pfx_alu_operand.sv
module pfx_alu_operand
  import pfx_alu_pkg::*;
(
  input  logic            wide,
  input  logic            use_reg,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [HLEN-1:0] imm_val,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb
);

  logic [XLEN-1:0] raw_b;

  always_comb begin
    raw_b = use_reg ? src_val : {{(XLEN-HLEN){imm_val[HLEN-1]}}, imm_val};
    opa   = wide ? dst_val : {{(XLEN-HLEN){1'b0}}, dst_val[HLEN-1:0]};
    opb   = wide ? raw_b   : {{(XLEN-HLEN){1'b0}}, raw_b[HLEN-1:0]};
  end

endmodule

// File: rtl/pfx_alu_simple.sv
module pfx_alu_simple
  import pfx_alu_pkg::*;
#(
  parameter bit HOST_BIG = 1'b0
) (
  input  alu_op_e         op,
  input  logic            wide,
  input  logic            order_big,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] dst_val,
  input  logic [HLEN-1:0] imm_val,
  output logic [XLEN-1:0] res,
  output logic            bad_width
);

  localparam int unsigned SHW   = $clog2(XLEN);
  localparam int unsigned NBYTE = XLEN / 8;

  logic [SHW-1:0]        shamt;
  logic signed [HLEN-1:0] ars_half;
  logic signed [XLEN-1:0] ars_full;
  logic [XLEN-1:0]       rev_full, rev_half, raw;
  logic [15:0]           rev_16;
  logic                  swap;
  logic [XLEN-1:0]       end_res;

  always_comb begin
    shamt    = wide ? opb[SHW-1:0] : {1'b0, opb[SHW-2:0]};
    ars_half = $signed(opa[HLEN-1:0]) >>> shamt[SHW-2:0];
    ars_full = $signed(opa) >>> shamt;
    rev_16   = {dst_val[7:0], dst_val[15:8]};
    rev_full = '0;
    rev_half = '0;
    for (int i = 0; i < NBYTE; i++) begin
      rev_full[8*i +: 8] = dst_val[8*(NBYTE-1-i) +: 8];
    end
    for (int i = 0; i < NBYTE/2; i++) begin
      rev_half[8*i +: 8] = dst_val[8*(NBYTE/2-1-i) +: 8];
    end
    swap      = order_big ^ HOST_BIG;
    bad_width = 1'b0;
    case (imm_val)
      HLEN'(16): end_res = swap ? {{(XLEN-16){1'b0}}, rev_16}
                                : {{(XLEN-16){1'b0}}, dst_val[15:0]};
      HLEN'(32): end_res = swap ? rev_half
                                : {{(XLEN-HLEN){1'b0}}, dst_val[HLEN-1:0]};
      HLEN'(64): end_res = swap ? rev_full : dst_val;
      default: begin
        end_res   = dst_val;
        bad_width = 1'b1;
      end
    endcase

    case (op)
      OP_ADD:  raw = opa + opb;
      OP_SUB:  raw = opa - opb;
      OP_MUL:  raw = opa * opb;
      OP_OR:   raw = opa | opb;
      OP_AND:  raw = opa & opb;
      OP_XOR:  raw = opa ^ opb;
      OP_LSH:  raw = opa << shamt;
      OP_RSH:  raw = opa >> shamt;
      OP_NEG:  raw = '0 - opa;
      OP_MOV:  raw = opb;
      OP_ARSH: raw = wide ? ars_full : {{(XLEN-HLEN){1'b0}}, ars_half};
      default: raw = end_res;
    endcase

    if (op == OP_END)   res = end_res;
    else if (!wide)     res = {{(XLEN-HLEN){1'b0}}, raw[HLEN-1:0]};
    else                res = raw;
  end

endmodule

// File: rtl/pfx_alu_divider.sv
module pfx_alu_divider #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         half,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         last,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_HALF = CW'(W / 2);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [W-1:0]  rem_d, quo_d, dvs_d;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          fits;
  logic          step_en;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~diff[W+1];
    rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_nxt = {quo_q[W-2:0], fits};
    last    = busy_q && (cnt_q == CW'(1));

    step_en = load || busy_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    if (load) begin
      rem_d  = '0;
      quo_d  = half ? (dividend << (W / 2)) : dividend;
      dvs_d  = divisor;
      cnt_d  = half ? CNT_HALF : CNT_FULL;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = rem_nxt;
      quo_d  = quo_nxt;
      cnt_d  = cnt_q - CW'(1);
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (step_en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R5: a running division always has steps left to take
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
  // R5: the division keeps running until its last step
  p_no_early_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);

endmodule

// File: rtl/pfx_alu_core.sv
module pfx_alu_core
  import pfx_alu_pkg::*;
#(
  parameter bit HOST_BIG = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic        wide,
  input  logic        use_reg,
  input  logic        ext_en,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  input  logic [31:0] imm_val,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        wr_en,
  output logic [63:0] result
);

  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  alu_op_e         op_e;
  logic [XLEN-1:0] opa, opb, simple_res;
  logic            bad_width;

  assign op_e = alu_op_e'(op);

  pfx_alu_operand u_operand (
    .wide    (wide),
    .use_reg (use_reg),
    .dst_val (dst_val),
    .src_val (src_val),
    .imm_val (imm_val),
    .opa     (opa),
    .opb     (opb)
  );

  pfx_alu_simple #(.HOST_BIG(HOST_BIG)) u_simple (
    .op        (op_e),
    .wide      (wide),
    .order_big (use_reg),
    .opa       (opa),
    .opb       (opb),
    .dst_val   (dst_val),
    .imm_val   (imm_val),
    .res       (simple_res),
    .bad_width (bad_width)
  );

  logic            div_op, sgn_op, mod_op, ill_now, zero_div, accept, launch;
  logic            a_neg, b_neg;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            dv_busy, dv_last;
  logic [XLEN-1:0] dv_quo, dv_rem;

  always_comb begin
    div_op   = is_div_op(op_e);
    sgn_op   = is_signed_div(op_e);
    mod_op   = (op_e == OP_MOD) || (op_e == OP_SMOD);
    ill_now  = (sgn_op && !ext_en) || ((op_e == OP_END) && bad_width);
    zero_div = div_op && (opb == '0);
    accept   = start && !dv_busy;
    launch   = accept && div_op && !ill_now && !zero_div;
    a_neg    = sgn_op && (wide ? opa[XLEN-1] : opa[HLEN-1]);
    b_neg    = sgn_op && (wide ? opb[XLEN-1] : opb[HLEN-1]);
    mag_a    = !a_neg ? opa : (wide ? ('0 - opa) : {{HLEN{1'b0}}, HLEN'(0) - opa[HLEN-1:0]});
    mag_b    = !b_neg ? opb : (wide ? ('0 - opb) : {{HLEN{1'b0}}, HLEN'(0) - opb[HLEN-1:0]});
  end

  pfx_alu_divider #(.W(XLEN)) u_divider (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (launch),
    .half     (!wide),
    .dividend (mag_a),
    .divisor  (mag_b),
    .busy     (dv_busy),
    .last     (dv_last),
    .quo_nxt  (dv_quo),
    .rem_nxt  (dv_rem)
  );

  // Context of the running division
  logic ctx_qneg_q, ctx_rneg_q, ctx_mod_q, ctx_wide_q;
  logic ctx_en;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctx_qneg_q <= 1'b0;
      ctx_rneg_q <= 1'b0;
      ctx_mod_q  <= 1'b0;
      ctx_wide_q <= 1'b0;
    end else if (ctx_en) begin
      ctx_qneg_q <= a_neg ^ b_neg;
      ctx_rneg_q <= a_neg;
      ctx_mod_q  <= mod_op;
      ctx_wide_q <= wide;
    end
  end
  assign ctx_en = launch;

  // Completion registers
  logic            done_q, done_d, ill_q, ill_d, res_en;
  logic [XLEN-1:0] res_q, res_d, div_fix, q_signed, r_signed, pick;

  always_comb begin
    q_signed = ctx_qneg_q ? ('0 - dv_quo) : dv_quo;
    r_signed = ctx_rneg_q ? ('0 - dv_rem) : dv_rem;
    pick     = ctx_mod_q ? r_signed : q_signed;
    div_fix  = ctx_wide_q ? pick : {{HLEN{1'b0}}, pick[HLEN-1:0]};

    done_d = 1'b0;
    ill_d  = ill_q;
    res_d  = res_q;
    if (dv_last) begin
      done_d = 1'b1;
      ill_d  = 1'b0;
      res_d  = div_fix;
    end else if (accept && !launch) begin
      done_d = 1'b1;
      ill_d  = ill_now;
      if (ill_now)       res_d = dst_val;
      else if (zero_div) res_d = mod_op ? opa : '0;
      else               res_d = simple_res;
    end
    res_en = done_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ill_q <= 1'b0;
      res_q <= '0;
    end else if (res_en) begin
      ill_q <= ill_d;
      res_q <= res_d;
    end
  end

  assign busy    = dv_busy;
  assign done    = done_q;
  assign illegal = done_q && ill_q;
  assign wr_en   = done_q && !ill_q;
  assign result  = res_q;

  // R1: single-cycle operations complete on the next edge
  p_fast_done_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && !div_op) |=> done_q);
  // R2: narrow-class results are zero-extended
  p_zext_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && !wide && !div_op && (op_e != OP_END) && !ill_now) |=> (result[63:32] == '0));
  // R5: no completion reported while the divider runs
  p_busy_no_done_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    dv_busy |-> !done_q);
  // R6: zero divisor completes immediately
  p_dbz_fast_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && zero_div && !ill_now) |=> (done_q && !dv_busy));
  // R8: signed division needs the extension enable
  p_ext_gate_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && sgn_op && !ext_en) |=> (illegal && !wr_en));

endmodule

// File: tb/test_pfx_alu_core.sv
module test_pfx_alu_core;

  logic        clk = 1'b0;
  logic        rst_n, start, wide, use_reg, ext_en;
  logic [3:0]  op;
  logic [63:0] dst_val, src_val;
  logic [31:0] imm_val;
  logic        busy, done, illegal, wr_en;
  logic [63:0] result;

  always #10 clk = ~clk;

  pfx_alu_core i_pfx_alu_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .use_reg(use_reg), .ext_en(ext_en), .dst_val(dst_val), .src_val(src_val),
    .imm_val(imm_val), .busy(busy), .done(done), .illegal(illegal),
    .wr_en(wr_en), .result(result)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  // reference model state
  bit          m_busy = 0, m_done = 0, m_ill = 0;
  int          m_cnt = 0;
  logic [63:0] m_res = '0, p_res = '0;
  string       m_tag = "R1", p_tag = "R1";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [3:0] o, input bit w, input bit ur, input bit ex,
                                 input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                                 output bit ill, output logic [63:0] r, output int lat);
    logic [63:0] a, b;
    longint x, y, q, rm;
    int sh, nb;
    ill = 0; lat = 0;
    b = ur ? s : {{32{im[31]}}, im};
    a = d;
    if (!w) begin a = {32'h0, d[31:0]}; b = {32'h0, b[31:0]}; end
    sh = w ? int'(b[5:0]) : int'(b[4:0]);
    r = '0;
    case (o)
      4'd0:  r = a + b;
      4'd1:  r = a - b;
      4'd2:  r = a * b;
      4'd4:  r = a | b;
      4'd5:  r = a & b;
      4'd10: r = a ^ b;
      4'd11: r = b;
      4'd8:  r = 64'h0 - a;
      4'd6:  r = a << sh;
      4'd7:  r = a >> sh;
      4'd12: begin
        if (w) x = $signed(a); else x = $signed(a[31:0]);
        r = x >>> sh;
      end
      4'd3, 4'd9: begin
        if (b == 0) r = (o == 4'd9) ? a : 64'h0;
        else begin r = (o == 4'd3) ? a / b : a % b; lat = w ? 64 : 32; end
      end
      4'd14, 4'd15: begin
        if (!ex) begin ill = 1; r = d; end
        else if (b == 0) r = (o == 4'd15) ? a : 64'h0;
        else begin
          if (w) begin x = $signed(a); y = $signed(b); end
          else begin x = $signed(a[31:0]); y = $signed(b[31:0]); end
          if (x == 64'sh8000_0000_0000_0000 && y == -1) begin q = x; rm = 0; end
          else begin q = x / y; rm = x % y; end
          r = (o == 4'd14) ? q : rm;
          lat = w ? 64 : 32;
        end
      end
      default: begin
        if (im == 16 || im == 32 || im == 64) begin
          nb = int'(im) / 8;
          for (int i = 0; i < nb; i++)
            r[8*i +: 8] = ur ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
        end else begin ill = 1; r = d; end
      end
    endcase
    if (!w && o != 4'd13 && !ill) r = {32'h0, r[31:0]};
  endfunction

  always @(posedge clk) begin
    bit ill; logic [63:0] r; int lat;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res; m_ill = 0; m_tag = p_tag;
        end
      end else if (start) begin
        ref_op(op, wide, use_reg, ext_en, dst_val, src_val, imm_val, ill, r, lat);
        if (lat == 0) begin
          m_done = 1; m_res = r; m_ill = ill; m_tag = cur_tag;
        end else begin
          m_busy = 1; m_cnt = lat; p_res = r; p_tag = cur_tag;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !finished) begin
      string t;
      t = m_busy ? p_tag : m_tag;
      chk(t, "busy", {63'h0, busy}, {63'h0, m_busy});
      chk(t, "done", {63'h0, done}, {63'h0, m_done});
      if (m_done) begin
        chk(m_tag, "illegal", {63'h0, illegal}, {63'h0, m_ill});
        chk(m_tag, "wr_en", {63'h0, wr_en}, {63'h0, !m_ill});
        chk(m_tag, "result", result, m_res);
      end
    end
  end

  task automatic issue(logic [3:0] o, bit w, bit ur, bit ex,
                       logic [63:0] d, logic [63:0] s, logic [31:0] im, string tag);
    @(negedge clk);
    op = o; wide = w; use_reg = ur; ext_en = ex;
    dst_val = d; src_val = s; imm_val = im;
    cur_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; wide = 1'b0; use_reg = 1'b0; ext_en = 1'b0;
    dst_val = '0; src_val = '0; imm_val = '0;
    repeat (3) @(negedge clk);
    chk("R12", "busy in reset", {63'h0, busy}, 64'h0);
    chk("R12", "done in reset", {63'h0, done}, 64'h0);
    chk("R12", "illegal in reset", {63'h0, illegal}, 64'h0);
    chk("R12", "wr_en in reset", {63'h0, wr_en}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1;

    // R1 wide arithmetic and logic
    issue(4'd0, 1, 1, 1, 64'h0000_0001_FFFF_FFFF, 64'h1, 32'h0, "R1");
    issue(4'd2, 1, 1, 1, 64'h0000_0001_0000_0003, 64'h5, 32'h0, "R1");
    issue(4'd11, 1, 0, 1, 64'h1234, 64'h0, 32'h8000_0000, "R1");
    issue(4'd10, 1, 1, 1, 64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F, 32'h0, "R1");
    issue(4'd8, 1, 1, 1, 64'h1, 64'h0, 32'h0, "R1");
    // R2 narrow class truncation
    issue(4'd0, 0, 1, 1, 64'h0000_0001_FFFF_FFFF, 64'h1, 32'h0, "R2");
    issue(4'd1, 0, 1, 1, 64'hABCD_0000_0000_0000, 64'h1, 32'h0, "R2");
    issue(4'd8, 0, 1, 1, 64'h1, 64'h0, 32'h0, "R2");
    // R4 immediate sign extension
    issue(4'd0, 1, 0, 1, 64'h5, 64'hDEAD, 32'hFFFF_FFFF, "R4");
    issue(4'd0, 0, 0, 1, 64'h5, 64'hDEAD, 32'hFFFF_FFFF, "R4");
    // R3 shifts
    issue(4'd6, 0, 1, 1, 64'h1, 64'd33, 32'h0, "R3");
    issue(4'd6, 1, 1, 1, 64'h1, 64'd65, 32'h0, "R3");
    issue(4'd7, 1, 1, 1, 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R3");
    issue(4'd12, 1, 1, 1, 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R3");
    issue(4'd12, 0, 0, 1, 64'h8000_0000, 64'h0, 32'd4, "R3");
    // R5 unsigned divide
    issue(4'd3, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 32'h0, "R5");
    issue(4'd9, 0, 1, 1, 64'h1_0000_0064, 64'd7, 32'h0, "R5");
    // R6 zero divisor
    issue(4'd3, 1, 1, 1, 64'h1234, 64'h0, 32'h0, "R6");
    issue(4'd9, 0, 1, 1, 64'h9999_0000_5555_1234, 64'h1_0000_0000, 32'h0, "R6");
    issue(4'd14, 1, 0, 1, 64'h77, 64'h0, 32'h0, "R6");
    // R7 signed divide
    issue(4'd14, 1, 0, 1, -64'sd7, 64'h0, 32'd2, "R7");
    issue(4'd15, 1, 0, 1, -64'sd7, 64'h0, 32'd2, "R7");
    issue(4'd14, 0, 0, 1, 64'h8000_0000, 64'h0, 32'hFFFF_FFFF, "R7");
    issue(4'd14, 1, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, "R7");
    // R8 signed divide without extension
    issue(4'd14, 1, 1, 0, 64'hCAFE, 64'h3, 32'h0, "R8");
    issue(4'd15, 0, 1, 0, 64'hFFFF_0000_CAFE, 64'h3, 32'h0, "R8");
    // R9 byte order conversion
    issue(4'd13, 1, 0, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R9");
    issue(4'd13, 1, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R9");
    issue(4'd13, 1, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R9");
    issue(4'd13, 0, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R9");
    issue(4'd13, 0, 0, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R9");
    // R10 bad width
    issue(4'd13, 1, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd8, "R10");
    issue(4'd13, 1, 0, 1, 64'hFEED, 64'h0, 32'd0, "R10");

    // R11 start pulse in the middle of a division
    @(negedge clk);
    op = 4'd3; wide = 1; use_reg = 1; ext_en = 1;
    dst_val = 64'h0123_4567_89AB_CDEF; src_val = 64'd1000; imm_val = '0;
    cur_tag = "R11"; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    op = 4'd0; dst_val = 64'h5; src_val = 64'h6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (m_busy) @(negedge clk);

    // random phase
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  o;
      logic [63:0] d, s;
      logic [31:0] im;
      string       tg;
      bit          ex;
      o  = 4'($urandom % 16);
      ex = ($urandom % 4) != 0;
      d  = {$urandom, $urandom};
      s  = (($urandom % 5) == 0) ? 64'h0 : {$urandom, $urandom};
      if (($urandom % 3) == 0) s = 64'($urandom % 70);
      im = (($urandom % 4) == 0) ? 32'h0 : $urandom;
      if (o == 4'd13) begin
        case ($urandom % 5)
          0: im = 32'd16; 1: im = 32'd32; 2: im = 32'd64; 3: im = 32'd8; default: im = 32'd48;
        endcase
      end
      case (o)
        4'd6, 4'd7, 4'd12: tg = "R3";
        4'd3, 4'd9:        tg = "R5";
        4'd14, 4'd15:      tg = ex ? "R7" : "R8";
        4'd13:             tg = "R9";
        default:           tg = "R1";
      endcase
      issue(o, 1'($urandom % 2), 1'($urandom % 2), ex, d, s, im, tg);
    end

    repeat (3) @(negedge clk);
    report();
  end

endmodule